// File: doc/BRIEF.md
# Byte-Packing Word FIFO Pair for a Serial Engine

The block sits between a register bus and a serial shift engine and buffers data in both directions with two 32-bit word FIFOs. The transmit FIFO takes words from the bus and hands them to the serializer one byte at a time, least significant byte first. The receive FIFO collects bytes from the deserializer, packs them into words and offers them to the bus. A configuration bit picks whether each entry holds a single byte or four bytes. In four-byte mode a short final word has its unused lanes filled with all ones.

Each FIFO has live full and empty flags, and a ready flag driven by its own 3-bit threshold. Each also has sticky overflow and underflow flags that a single clear input resets. A flush request empties both FIFOs and discards any byte held on the serial side. Its busy indication drops by itself once the flush is done.

Top module: `xfer_fifo_pair`

## Requirements
- R1: After synchronous reset both FIFOs are empty and not full. All four sticky flags, `flush_busy` and `ser_tx_avail` are 0.
- R2: In four-byte mode (`cfg_byte4`=1) each transmit entry yields four bytes on `ser_tx_byte`: bits 7:0 first, then 15:8, 23:16 and 31:24. Entries leave in the order they were pushed.
- R3: A transmit push in four-byte mode keeps lanes 0 to `bus_wr_bytes` (a count minus one) of `bus_wr_data`. It replaces every higher lane with 8'hFF, and those padding bytes are shifted out as well.
- R4: In one-byte mode (`cfg_byte4`=0) a transmit push stores only lane 0 and yields exactly one byte. Each received byte becomes its own entry, read as {24'hFFFFFF, byte}.
- R5: In four-byte mode received bytes fill lanes 0,1,2,3 in arrival order. A word is pushed when lane 3 is filled or when `ser_rx_last` accompanies the byte, and unfilled lanes read 8'hFF.
- R6: Each FIFO holds 8 entries. Full and empty follow the occupancy in the same cycle. The serial side of the transmit path takes one entry out of the FIFO into its shift register as soon as that register is idle.
- R7: `rf_ready` is 1 when the receive occupancy is greater than `cfg_rd_thr`. `wf_ready` is 1 when the transmit free space is greater than `cfg_wr_thr`.
- R8: A push into a full FIFO is dropped, leaving the contents unchanged, and sets that FIFO's overflow flag. The flag stays set until cleared.
- R9: A bus pop from an empty receive FIFO leaves `bus_rd_data` at its last value and sets `rf_unf`. A `ser_tx_take` while `ser_tx_avail` is 0 sets `wf_unf`.
- R10: `err_clr` clears all four sticky flags at the next edge.
- R11: A `flush_req` sampled at an edge raises `flush_busy` for exactly one cycle. At the end of that cycle both FIFOs, the transmit shift register and the partial receive word are emptied. Pushes, pops and received bytes during that cycle are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_byte4 | input | 1 | 1: four bytes per entry, 0: one byte per entry |
| cfg_wr_thr | input | 3 | Transmit ready threshold (free entries) |
| cfg_rd_thr | input | 3 | Receive ready threshold (occupied entries) |
| flush_req | input | 1 | Request to empty both FIFOs |
| flush_busy | output | 1 | Flush in progress, self-clearing |
| err_clr | input | 1 | Clear all sticky overflow/underflow flags |
| bus_wr_push | input | 1 | Push a word into the transmit FIFO |
| bus_wr_data | input | 32 | Transmit word, byte 0 in bits 7:0 |
| bus_wr_bytes | input | 2 | Valid byte count minus one (four-byte mode) |
| bus_rd_pop | input | 1 | Pop a word from the receive FIFO |
| bus_rd_data | output | 32 | Registered receive word, valid the cycle after a pop |
| ser_tx_take | input | 1 | Serializer consumes the current byte |
| ser_tx_avail | output | 1 | A transmit byte is available |
| ser_tx_byte | output | 8 | Current transmit byte |
| ser_rx_valid | input | 1 | Deserializer delivers a byte |
| ser_rx_byte | input | 8 | Received byte |
| ser_rx_last | input | 1 | Received byte ends the current word |
| wf_full | output | 1 | Transmit FIFO full |
| wf_empty | output | 1 | Transmit FIFO empty |
| wf_ready | output | 1 | Transmit free space above threshold |
| wf_ovf | output | 1 | Sticky transmit overflow |
| wf_unf | output | 1 | Sticky transmit underflow (serializer starved) |
| rf_full | output | 1 | Receive FIFO full |
| rf_empty | output | 1 | Receive FIFO empty |
| rf_ready | output | 1 | Receive occupancy above threshold |
| rf_ovf | output | 1 | Sticky receive overflow |
| rf_unf | output | 1 | Sticky receive underflow |

## Verification
The bench builds the block with its default depth of 8 entries, 32-bit words and 3-bit thresholds. Eight entries are few enough for short bursts to reach both full and overflow in each direction, and to underflow them again. The 3-bit thresholds can be set on both sides of a real occupancy, so the ready flags are seen switching on and off. Both entry modes are run, and a flush is issued while the transmit FIFO, its shift register and a half-packed receive word all hold data.

// File: rtl/xfp_pkg.sv
package xfp_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/xfp_word_fifo.sv
module xfp_word_fifo #(
  parameter int unsigned W             = 32,
  parameter int unsigned DEPTH         = 8,
  parameter int unsigned THR_W         = 3,
  parameter bit          READY_ON_FREE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             err_clr,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  input  logic             unf_evt,
  input  logic [THR_W-1:0] thr,
  output logic [W-1:0]     pop_data,
  output logic             full,
  output logic             empty,
  output logic             ready,
  output logic             ovf,
  output logic             unf
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1) > THR_W ? $clog2(DEPTH + 1) : THR_W + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  // storage without reset so that block RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)         pop_data <= '0;
    else if (do_pop) pop_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || err_clr) begin
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      if (push && full && !flush)      ovf <= 1'b1;
      if ((pop && empty) || unf_evt)   unf <= 1'b1;
    end
  end

  generate
    if (READY_ON_FREE) begin : g_free
      assign ready = (CW'(DEPTH) - count) > CW'(thr);
    end else begin : g_used
      assign ready = count > CW'(thr);
    end
  endgenerate
endmodule

// File: rtl/xfp_tx_unpack.sv
module xfp_tx_unpack
  import xfp_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              byte4,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_data,
  output logic              fifo_pop,
  input  logic              take,
  output logic              avail,
  output byte_t             byte_out,
  output logic              starve
);
  localparam int unsigned LANES = WORD_W / BYTE_W;
  localparam int unsigned LW    = $clog2(LANES + 1);

  logic [WORD_W-1:0] shreg;
  logic [LW-1:0]     left;
  logic              loading;

  assign avail    = (left != '0);
  assign byte_out = shreg[BYTE_W-1:0];
  assign starve   = take && !avail;
  assign fifo_pop = !avail && !loading && !fifo_empty && !flush;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      shreg   <= '1;
      left    <= '0;
      loading <= 1'b0;
    end else if (loading) begin
      shreg   <= fifo_data;
      left    <= byte4 ? LW'(LANES) : LW'(1);
      loading <= 1'b0;
    end else if (fifo_pop) begin
      loading <= 1'b1;
    end else if (take && avail) begin
      shreg <= {{BYTE_W{1'b1}}, shreg[WORD_W-1:BYTE_W]};
      left  <= left - 1'b1;
    end
  end
endmodule

// File: rtl/xfp_rx_pack.sv
module xfp_rx_pack
  import xfp_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              byte4,
  input  logic              in_valid,
  input  byte_t             in_byte,
  input  logic              in_last,
  output logic              push,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned LANES = WORD_W / BYTE_W;
  localparam int unsigned LIW   = (LANES > 1) ? $clog2(LANES) : 1;

  logic [WORD_W-1:0] acc, merged;
  logic [LIW-1:0]    lane;

  always_comb begin
    merged = acc;
    for (int i = 0; i < LANES; i++) begin
      if (lane == LIW'(i)) merged[i*BYTE_W +: BYTE_W] = in_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      acc  <= '1;
      lane <= '0;
      push <= 1'b0;
      word <= '1;
    end else begin
      push <= 1'b0;
      if (in_valid) begin
        if (!byte4) begin
          word <= {{(WORD_W-BYTE_W){1'b1}}, in_byte};
          push <= 1'b1;
        end else if (in_last || lane == LIW'(LANES - 1)) begin
          word <= merged;
          push <= 1'b1;
          acc  <= '1;
          lane <= '0;
        end else begin
          acc  <= merged;
          lane <= lane + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xfer_fifo_pair.sv
module xfer_fifo_pair
  import xfp_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned THR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_byte4,
  input  logic [THR_W-1:0]  cfg_wr_thr,
  input  logic [THR_W-1:0]  cfg_rd_thr,
  input  logic              flush_req,
  output logic              flush_busy,
  input  logic              err_clr,
  input  logic              bus_wr_push,
  input  logic [WORD_W-1:0] bus_wr_data,
  input  logic [1:0]        bus_wr_bytes,
  input  logic              bus_rd_pop,
  output logic [WORD_W-1:0] bus_rd_data,
  input  logic              ser_tx_take,
  output logic              ser_tx_avail,
  output logic [7:0]        ser_tx_byte,
  input  logic              ser_rx_valid,
  input  logic [7:0]        ser_rx_byte,
  input  logic              ser_rx_last,
  output logic              wf_full,
  output logic              wf_empty,
  output logic              wf_ready,
  output logic              wf_ovf,
  output logic              wf_unf,
  output logic              rf_full,
  output logic              rf_empty,
  output logic              rf_ready,
  output logic              rf_ovf,
  output logic              rf_unf
);
  localparam int unsigned LANES = WORD_W / BYTE_W;

  logic [WORD_W-1:0] wr_entry, tx_word, rx_word;
  logic              tx_pop, tx_starve, rx_push;

  always_ff @(posedge clk) begin
    if (rst)             flush_busy <= 1'b0;
    else if (flush_busy) flush_busy <= 1'b0;
    else if (flush_req)  flush_busy <= 1'b1;
  end

  // lanes beyond the valid count are padded with ones
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      if (i == 0 || (cfg_byte4 && i <= int'(bus_wr_bytes)))
        wr_entry[i*BYTE_W +: BYTE_W] = bus_wr_data[i*BYTE_W +: BYTE_W];
      else
        wr_entry[i*BYTE_W +: BYTE_W] = '1;
    end
  end

  xfp_word_fifo #(.W(WORD_W), .DEPTH(DEPTH), .THR_W(THR_W), .READY_ON_FREE(1'b1)) u_tx_fifo (
    .clk(clk), .rst(rst), .flush(flush_busy), .err_clr(err_clr),
    .push(bus_wr_push), .push_data(wr_entry),
    .pop(tx_pop), .unf_evt(tx_starve), .thr(cfg_wr_thr),
    .pop_data(tx_word), .full(wf_full), .empty(wf_empty), .ready(wf_ready),
    .ovf(wf_ovf), .unf(wf_unf)
  );

  xfp_tx_unpack #(.WORD_W(WORD_W)) u_tx_unpack (
    .clk(clk), .rst(rst), .flush(flush_busy), .byte4(cfg_byte4),
    .fifo_empty(wf_empty), .fifo_data(tx_word), .fifo_pop(tx_pop),
    .take(ser_tx_take), .avail(ser_tx_avail), .byte_out(ser_tx_byte),
    .starve(tx_starve)
  );

  xfp_rx_pack #(.WORD_W(WORD_W)) u_rx_pack (
    .clk(clk), .rst(rst), .flush(flush_busy), .byte4(cfg_byte4),
    .in_valid(ser_rx_valid), .in_byte(ser_rx_byte), .in_last(ser_rx_last),
    .push(rx_push), .word(rx_word)
  );

  xfp_word_fifo #(.W(WORD_W), .DEPTH(DEPTH), .THR_W(THR_W), .READY_ON_FREE(1'b0)) u_rx_fifo (
    .clk(clk), .rst(rst), .flush(flush_busy), .err_clr(err_clr),
    .push(rx_push), .push_data(rx_word),
    .pop(bus_rd_pop), .unf_evt(1'b0), .thr(cfg_rd_thr),
    .pop_data(bus_rd_data), .full(rf_full), .empty(rf_empty), .ready(rf_ready),
    .ovf(rf_ovf), .unf(rf_unf)
  );
endmodule

// File: rtl/xfer_fifo_pair_chk.sv
module xfer_fifo_pair_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              err_clr,
  input logic              flush_busy,
  input logic              bus_rd_pop,
  input logic [WORD_W-1:0] bus_rd_data,
  input logic              ser_tx_avail,
  input logic              wf_full,
  input logic              wf_empty,
  input logic              wf_ready,
  input logic              wf_ovf,
  input logic              rf_full,
  input logic              rf_empty,
  input logic              rf_ready,
  input logic              rf_ovf,
  input logic              rf_unf
);
  p_tx_flags_r6: assert property (@(posedge clk) disable iff (rst) !(wf_full && wf_empty));
  p_rx_flags_r6: assert property (@(posedge clk) disable iff (rst) !(rf_full && rf_empty));
  p_rx_ready_r7: assert property (@(posedge clk) disable iff (rst) rf_empty |-> !rf_ready);
  p_tx_ready_r7: assert property (@(posedge clk) disable iff (rst) wf_full |-> !wf_ready);
  p_tx_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (wf_ovf && !err_clr) |=> wf_ovf);
  p_rx_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (rf_ovf && !err_clr) |=> rf_ovf);
  p_rx_unf_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_pop && rf_empty && !err_clr) |=> ($stable(bus_rd_data) && rf_unf));
  p_flush_once_r11: assert property (@(posedge clk) disable iff (rst)
    flush_busy |=> !flush_busy);
  p_flush_empties_r11: assert property (@(posedge clk) disable iff (rst)
    flush_busy |=> (wf_empty && rf_empty && !ser_tx_avail));
endmodule

bind xfer_fifo_pair xfer_fifo_pair_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .err_clr(err_clr), .flush_busy(flush_busy),
  .bus_rd_pop(bus_rd_pop), .bus_rd_data(bus_rd_data), .ser_tx_avail(ser_tx_avail),
  .wf_full(wf_full), .wf_empty(wf_empty), .wf_ready(wf_ready), .wf_ovf(wf_ovf),
  .rf_full(rf_full), .rf_empty(rf_empty), .rf_ready(rf_ready), .rf_ovf(rf_ovf),
  .rf_unf(rf_unf)
);

// File: tb/test_xfer_fifo_pair.sv
module test_xfer_fifo_pair;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_byte4 = 1'b1;
  logic [2:0]  cfg_wr_thr = 3'd3, cfg_rd_thr = 3'd2;
  logic        flush_req = 1'b0, err_clr = 1'b0;
  logic        bus_wr_push = 1'b0, bus_rd_pop = 1'b0;
  logic [31:0] bus_wr_data = '0;
  logic [1:0]  bus_wr_bytes = 2'd3;
  logic        ser_tx_take = 1'b0, ser_rx_valid = 1'b0, ser_rx_last = 1'b0;
  logic [7:0]  ser_rx_byte = '0;
  logic        flush_busy, ser_tx_avail;
  logic [31:0] bus_rd_data;
  logic [7:0]  ser_tx_byte;
  logic        wf_full, wf_empty, wf_ready, wf_ovf, wf_unf;
  logic        rf_full, rf_empty, rf_ready, rf_ovf, rf_unf;

  int checks = 0, errors = 0;
  logic [7:0]  txq[$];
  logic [31:0] rxq[$];

  always #5 clk = ~clk;

  xfer_fifo_pair i_xfer_fifo_pair (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // driver: pushes a bus word and records the bytes the serializer must see
  task automatic wr(logic [31:0] d, logic [1:0] nb, bit keep);
    bus_wr_push = 1'b1; bus_wr_data = d; bus_wr_bytes = nb;
    @(negedge clk);
    bus_wr_push = 1'b0;
    if (keep) begin
      if (cfg_byte4) begin
        for (int i = 0; i < 4; i++) txq.push_back(i <= int'(nb) ? d[i*8 +: 8] : 8'hFF);
      end else begin
        txq.push_back(d[7:0]);
      end
    end
  endtask

  // monitor on the serial side: takes bytes and compares to the queue head
  task automatic drain_tx(int n, string req);
    for (int k = 0; k < n; k++) begin
      int g = 0;
      while (!ser_tx_avail && g < 50) begin @(negedge clk); g++; end
      chk(req, {24'd0, ser_tx_byte}, {24'd0, txq.pop_front()});
      ser_tx_take = 1'b1;
      @(negedge clk);
      ser_tx_take = 1'b0;
    end
  endtask

  task automatic rx(logic [7:0] b, bit last);
    ser_rx_valid = 1'b1; ser_rx_byte = b; ser_rx_last = last;
    @(negedge clk);
    ser_rx_valid = 1'b0; ser_rx_last = 1'b0;
  endtask

  task automatic rd_check(string req);
    bus_rd_pop = 1'b1;
    @(negedge clk);
    bus_rd_pop = 1'b0;
    chk(req, bus_rd_data, rxq.pop_front());
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic run_all();
    cyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 wf_empty", wf_empty, 1);   chk("R1 rf_empty", rf_empty, 1);
    chk("R1 wf_full", wf_full, 0);     chk("R1 rf_full", rf_full, 0);
    chk("R1 sticky", {wf_ovf, wf_unf, rf_ovf, rf_unf}, 0);
    chk("R1 flush_busy", flush_busy, 0); chk("R1 avail", ser_tx_avail, 0);

    // R2 full word order, R3 padded short word
    wr(32'h44332211, 2'd3, 1);
    wr(32'hA1B2C3D4, 2'd1, 1);
    drain_tx(8, "R2_R3 tx byte");

    // R4 one-byte entries
    cfg_byte4 = 1'b0;
    wr(32'h000000AB, 2'd3, 1);
    wr(32'h12345678, 2'd3, 1);
    drain_tx(2, "R4 tx byte");
    cyc(4);
    chk("R4 no extra byte", ser_tx_avail, 0);

    // R6/R7/R8 transmit occupancy, threshold, overflow
    cfg_byte4 = 1'b1;
    for (int i = 0; i < 5; i++) wr(32'hC0DE0000 + i, 2'd3, 1);
    cyc(3);
    chk("R7 wf_ready free4>3", wf_ready, 1);
    cfg_wr_thr = 3'd4; #1;
    chk("R7 wf_ready free4>4", wf_ready, 0);
    cfg_wr_thr = 3'd3;
    @(negedge clk);
    for (int i = 5; i < 9; i++) wr(32'hC0DE0000 + i, 2'd3, 1);
    chk("R6 wf_full", wf_full, 1);
    chk("R8 wf_ovf before", wf_ovf, 0);
    wr(32'hDEADBEEF, 2'd3, 0);
    chk("R8 wf_ovf", wf_ovf, 1);
    chk("R7 wf_ready full", wf_ready, 0);
    drain_tx(36, "R8 kept contents");
    cyc(4);
    chk("R6 wf_empty drained", wf_empty, 1);
    chk("R8 wf_ovf sticky", wf_ovf, 1);
    // R9 serializer starve
    ser_tx_take = 1'b1; @(negedge clk); ser_tx_take = 1'b0;
    chk("R9 wf_unf", wf_unf, 1);
    pulse_clr();
    chk("R10 wf cleared", {wf_ovf, wf_unf}, 0);

    // receive side in one-byte mode
    cfg_byte4 = 1'b0;
    rx(8'h10, 0); rx(8'h11, 0);
    cyc(2);
    chk("R7 rf_ready occ2>2", rf_ready, 0);
    rx(8'h12, 0);
    cyc(2);
    chk("R7 rf_ready occ3>2", rf_ready, 1);
    for (int i = 3; i < 9; i++) rx(8'h10 + 8'(i), 0);
    cyc(2);
    for (int i = 0; i < 8; i++) rxq.push_back({24'hFFFFFF, 8'h10 + 8'(i)});
    chk("R6 rf_full", rf_full, 1);
    chk("R8 rf_ovf", rf_ovf, 1);
    for (int i = 0; i < 8; i++) rd_check("R4_R8 rx word");
    chk("R6 rf_empty", rf_empty, 1);
    rxq.push_back(32'hFFFFFF17);
    rd_check("R9 rx underflow holds data");
    chk("R9 rf_unf", rf_unf, 1);
    pulse_clr();
    chk("R10 rf cleared", {rf_ovf, rf_unf}, 0);

    // R5 receive packing
    cfg_byte4 = 1'b1;
    rx(8'h01, 0); rx(8'h02, 0); rx(8'h03, 0); rx(8'h04, 0);
    rx(8'h05, 0); rx(8'h06, 1);
    cyc(2);
    rxq.push_back(32'h04030201); rxq.push_back(32'hFFFF0605);
    rd_check("R5 full word");
    rd_check("R5 short word");

    // R11 flush with data everywhere
    wr(32'h11111111, 2'd3, 0); wr(32'h22222222, 2'd3, 0); wr(32'h33333333, 2'd3, 0);
    rx(8'h77, 0); rx(8'h88, 0);
    cyc(3);
    chk("R11 pre wf_empty", wf_empty, 0);
    flush_req = 1'b1; @(negedge clk); flush_req = 1'b0;
    chk("R11 busy", flush_busy, 1);
    @(negedge clk);
    chk("R11 busy cleared", flush_busy, 0);
    chk("R11 wf_empty", wf_empty, 1);
    chk("R11 rf_empty", rf_empty, 1);
    chk("R11 avail", ser_tx_avail, 0);
    rx(8'hAA, 0); rx(8'hBB, 0); rx(8'hCC, 0); rx(8'hDD, 0);
    cyc(2);
    rxq.push_back(32'hDDCCBBAA);
    rd_check("R11 partial word discarded");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule